// File: doc/BRIEF.md
# Next-Instruction Priority Dispatcher

At the end of every instruction the control sequencer asks this block where to go next. The block looks at a set of pending conditions and turns them into a 4-bit dispatch offset. The conditions are an interrupt cycle already under way, the run flip-flop, a performance-meter request, an interrupt-system request, a statistics-tracking enable, a trap request, and a flag saying that the next instruction address lies in the register-file range. A fixed priority decides the offset. The trap request has no priority level of its own. Instead it sets the low bit of the target in the tracking, normal and register-file cases.

The register-file address flag needs time to settle after an instruction fetch. A request that arrives too soon after a fetch is therefore held back rather than evaluated. It is evaluated on the first cycle that the spacing rule allows, using the condition inputs present in that cycle. The result is registered: `valid_o` pulses for one cycle and `offset_o` keeps its value until the next dispatch.

Top module: `nd_dispatch`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` is 0 and `offset_o` is 0 until a request is accepted.
- R2: An accepted request with `intr_cyc_i` high dispatches to offset 0, whatever the other inputs are.
- R3: With no interrupt cycle and `run_i` low, the offset is 2.
- R4: With the above absent, `meter_req_i` gives offset 4; otherwise `intr_req_i` gives offset 6.
- R5: With the above absent and `track_en_i` high, the offset is octal 10, or octal 11 when `trap_req_i` is also high.
- R6: With the above absent and `trap_req_i` high, the offset is octal 13, or octal 17 when `regfile_addr_i` is also high.
- R7: With the above absent, `regfile_addr_i` gives octal 16; with nothing pending the offset is octal 12.
- R8: Whenever `valid_o` is high, `offset_o` is one of 0, 2, 4, 6, 8, 9, 10, 11, 14 or 15 (decimal).
- R9: A request accepted on a clock edge gives `valid_o` high for the following cycle only. `offset_o` holds its value while `valid_o` is low.
- R10: A request made in the `MIN_GAP` cycles after an edge that sampled `fetch_i` high is deferred. It is evaluated on the first edge outside that window, using the condition inputs present on that edge.
- R11: Further requests that arrive while a request is deferred merge into it and produce only one dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Dispatch request at end of instruction |
| fetch_i | input | 1 | An instruction fetch is issued this cycle |
| intr_cyc_i | input | 1 | Interrupt cycle in progress |
| run_i | input | 1 | Run flip-flop, low means halt |
| meter_req_i | input | 1 | Performance-meter request |
| intr_req_i | input | 1 | Interrupt-system request ready |
| track_en_i | input | 1 | Statistics tracking enabled |
| trap_req_i | input | 1 | Trap requested by the last instruction |
| regfile_addr_i | input | 1 | Next instruction address is in the register file |
| valid_o | output | 1 | One-cycle strobe for a new offset |
| offset_o | output | 4 | Dispatch offset |

## Verification
The assertions check on every cycle that a strobed offset is a legal value, and that no evaluation happens in the cycle right after a fetch. They also check that an accepted request is followed by a strobe, and that the interrupt-cycle, halt and trap-bit rules hold for the inputs sampled on the accepting edge. The bench's scenarios cover the remaining behaviour. A full sweep of all 128 condition patterns checks the whole priority order. Directed sequences check the deferred evaluation, including which input values a deferred request uses. They also check that several requests made inside the blocked window merge into a single strobe.

// File: rtl/nd_pkg.sv
package nd_pkg;
  localparam int OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_INTR_CYC  = 4'o00;
  localparam logic [OFS_W-1:0] OFS_HALT      = 4'o02;
  localparam logic [OFS_W-1:0] OFS_METER     = 4'o04;
  localparam logic [OFS_W-1:0] OFS_INTR_REQ  = 4'o06;
  localparam logic [OFS_W-1:0] OFS_TRACK     = 4'o10;
  localparam logic [OFS_W-1:0] OFS_NORMAL    = 4'o12;
  localparam logic [OFS_W-1:0] OFS_TRAP      = 4'o13;
  localparam logic [OFS_W-1:0] OFS_REGFILE   = 4'o16;

  typedef struct packed {
    logic intr_cyc;
    logic run;
    logic meter_req;
    logic intr_req;
    logic track_en;
    logic trap_req;
    logic regfile_addr;
  } cond_t;
endpackage

// File: rtl/nd_prio.sv
module nd_prio
  import nd_pkg::*;
(
  input  cond_t             cond_i,
  output logic [OFS_W-1:0]  offset_o
);
  always_comb begin
    if (cond_i.intr_cyc)       offset_o = OFS_INTR_CYC;
    else if (!cond_i.run)      offset_o = OFS_HALT;
    else if (cond_i.meter_req) offset_o = OFS_METER;
    else if (cond_i.intr_req)  offset_o = OFS_INTR_REQ;
    else if (cond_i.track_en)  offset_o = OFS_TRACK | {{(OFS_W-1){1'b0}}, cond_i.trap_req};
    else if (cond_i.trap_req)  offset_o = cond_i.regfile_addr ? (OFS_REGFILE | 4'o01) : OFS_TRAP;
    else if (cond_i.regfile_addr) offset_o = OFS_REGFILE;
    else                       offset_o = OFS_NORMAL;
  end
endmodule

// File: rtl/nd_gap_guard.sv
module nd_gap_guard #(
  parameter int MIN_GAP = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fetch_i,
  output logic fire_o
);
  localparam int CW = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1);

  logic blocked;
  logic pend_q;
  logic want;

  generate
    if (MIN_GAP == 0) begin : g_nogap
      assign blocked = 1'b0;
    end else begin : g_gap
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (fetch_i)        cnt_q <= CW'(MIN_GAP);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign blocked = (cnt_q != '0);

      // R10: never evaluate on the edge right after a fetch
      a_r10_no_fire_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(fetch_i) |-> !fire_o);
    end
  endgenerate

  assign want   = req_i | pend_q;
  assign fire_o = want & ~blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want & blocked;
  end
endmodule

// File: rtl/nd_out_reg.sv
module nd_out_reg
  import nd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic             valid_o,
  output logic [OFS_W-1:0] offset_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      offset_o <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) offset_o <= offset_i;
    end
  end
endmodule

// File: rtl/nd_dispatch.sv
module nd_dispatch
  import nd_pkg::*;
#(
  parameter int MIN_GAP = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             fetch_i,
  input  logic             intr_cyc_i,
  input  logic             run_i,
  input  logic             meter_req_i,
  input  logic             intr_req_i,
  input  logic             track_en_i,
  input  logic             trap_req_i,
  input  logic             regfile_addr_i,
  output logic             valid_o,
  output logic [OFS_W-1:0] offset_o
);
  cond_t            cond;
  logic [OFS_W-1:0] next_ofs;
  logic             fire;

  assign cond = '{intr_cyc: intr_cyc_i, run: run_i, meter_req: meter_req_i,
                  intr_req: intr_req_i, track_en: track_en_i,
                  trap_req: trap_req_i, regfile_addr: regfile_addr_i};

  nd_prio u_prio (.cond_i(cond), .offset_o(next_ofs));

  nd_gap_guard #(.MIN_GAP(MIN_GAP)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .fetch_i(fetch_i), .fire_o(fire));

  nd_out_reg u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire),
    .offset_i(next_ofs), .valid_o(valid_o), .offset_o(offset_o));

  a_r8_legal_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (offset_o inside {4'o00, 4'o02, 4'o04, 4'o06, 4'o10,
                                  4'o11, 4'o12, 4'o13, 4'o16, 4'o17}));

  a_r9_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> valid_o);

  a_r2_intr_cycle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && intr_cyc_i |=> offset_o == 4'o00);

  a_r3_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !intr_cyc_i && !run_i |=> offset_o == 4'o02);

  // R5/R6: trap folds into the low bit once the higher requests are absent
  a_r6_trap_low_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !intr_cyc_i && run_i && !meter_req_i && !intr_req_i && trap_req_i
    |=> offset_o[0]);
endmodule

// File: tb/nd_dispatch_test.sv
module nd_dispatch_test;
  logic clk = 0;
  logic rst_n = 0;
  logic req = 0, fetch = 0;
  logic [6:0] cv = 7'b0000010;
  logic valid;
  logic [3:0] ofs;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nd_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .fetch_i(fetch),
    .intr_cyc_i(cv[0]), .run_i(cv[1]), .meter_req_i(cv[2]),
    .intr_req_i(cv[3]), .track_en_i(cv[4]), .trap_req_i(cv[5]),
    .regfile_addr_i(cv[6]), .valid_o(valid), .offset_o(ofs));

  function automatic logic [3:0] model(input logic [6:0] c);
    if (c[0])      return 4'd0;
    if (!c[1])     return 4'd2;
    if (c[2])      return 4'd4;
    if (c[3])      return 4'd6;
    if (c[4])      return c[5] ? 4'd9 : 4'd8;
    if (c[5])      return c[6] ? 4'd15 : 4'd11;
    if (c[6])      return 4'd14;
    return 4'd10;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk("R1 in reset", {valid, ofs}, 5'h00);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 after reset", {valid, ofs}, 5'h00);

    // R2..R8: full sweep of the condition space
    for (int i = 0; i < 128; i++) begin
      cv = 7'(i); req = 1;
      @(negedge clk);
      req = 0;
      chk($sformatf("R2-R8 sweep %0d (R2 R3 R4 R5 R6 R7 R8)", i), {valid, ofs}, {1'b1, model(7'(i))});
    end
    @(negedge clk);
    chk("R9 strobe drops, offset held", {valid, ofs}, {1'b0, model(7'd127)});

    // R10: deferred request uses inputs on its evaluation edge
    fetch = 1; @(negedge clk);
    fetch = 0; req = 1; cv = 7'b0000010; @(negedge clk);
    chk("R10 blocked after fetch", {4'b0, valid}, 5'h0);
    req = 0; cv = 7'b0000110; @(negedge clk);
    chk("R10 deferred dispatch", {valid, ofs}, {1'b1, 4'd4});
    @(negedge clk);
    chk("R9 single pulse", {4'b0, valid}, 5'h0);

    // R11: two requests inside blocked window merge into one
    fetch = 1; @(negedge clk);
    fetch = 0; req = 1; cv = 7'b1100010; @(negedge clk);
    chk("R11 still blocked", {4'b0, valid}, 5'h0);
    req = 1; @(negedge clk);
    req = 0;
    chk("R11 merged dispatch", {valid, ofs}, {1'b1, 4'd15});
    @(negedge clk);
    chk("R11 no second dispatch", {4'b0, valid}, 5'h0);

    // R10: repeated fetches keep deferring
    fetch = 1; req = 1; cv = 7'b0010010; @(negedge clk);
    chk("R10 same-cycle fetch not blocked", {valid, ofs}, {1'b1, 4'd8});
    req = 0; @(negedge clk);
    fetch = 0; req = 1; @(negedge clk);
    req = 0;
    chk("R10 blocked by back-to-back fetch", {4'b0, valid}, 5'h0);
    @(negedge clk);
    chk("R10 fires after gap", {valid, ofs}, {1'b1, 4'd8});
    @(negedge clk);
    chk("R9 idle", {4'b0, valid}, 5'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule